// File: doc/BRIEF.md
# Multi-Channel Fault Status Reporter

This block assembles the status byte that a serial control port shifts out on every transaction of a multi-channel high-side gate driver. It merges two system-level fault indications (charge pump undervoltage and over-temperature warning) with the latched load faults of each output channel. The load faults are short-to-ground, short-to-battery and open load. Detection of those faults happens elsewhere. This block only reports them.

A single byte carries the load faults of only one channel. When faults sit on several channels, the block rotates through the faulted channels in ascending order and reports one channel per transaction, so the host reads everything by repeating transactions until the reported channel number stops increasing. The system flags are read-to-clear: a flag that was raised stays visible after its condition ends, and the next completed read drops it. The host marks a completed read with a one-cycle `rd_done` strobe. An active-low summary line goes low whenever any fault is visible.

Top module: `fault_status_reporter`

## Requirements
- R1: After reset, with no fault inputs active, `status_byte` is 8'h00 and `fault_n` is 1. The poll pointer starts at channel 1, which is address code 00.
- R2: Bit 5 of `status_byte` is always 0. With no load fault on any channel and no system flag, the whole byte is 8'h00.
- R3: With only system faults, bits 7:6 are 00. Bit 4 shows charge pump undervoltage and bit 3 shows thermal warning, and both may be set together. Each bit is set while its live input is high or its latched flag is set.
- R4: When the reported channel has load faults, bits 7:6 carry that channel's address code, which is the channel number minus one. Bit 2 shows open load, bit 1 short-to-battery and bit 0 short-to-ground. The system bits of R3 appear in the same byte. Example: short-to-battery on channel 3 gives 8'b10000010.
- R5: With load faults on several channels, each `rd_done` moves the report to the next faulted channel in ascending order. After the highest faulted channel it wraps to the lowest. Example: open load on channel 2 and short-to-ground on channel 4 give 8'b01000100, then 8'b11000001, then 8'b01000100.
- R6: The reported channel is the lowest faulted channel at or above the poll pointer. If there is none, it is the lowest faulted channel overall. On `rd_done`, the pointer moves to one above the reported channel, wrapping from the last channel to the first.
- R7: A system flag stays set after its live input falls, until a `rd_done` arrives.
- R8: A `rd_done` clears a system flag only if its live input is low in that cycle. A flag whose condition is still active stays set.
- R9: `fault_n` is 0 exactly when any channel has a load fault or any system bit is set.
- R10: Without `rd_done`, the reported channel does not change while the load fault inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_uv_live | input | 1 | Live charge pump undervoltage condition |
| therm_live | input | 1 | Live thermal warning condition |
| ch_stg | input | NUM_CH | Latched short-to-ground per channel (bit i = channel i+1) |
| ch_stb | input | NUM_CH | Latched short-to-battery per channel |
| ch_ol | input | NUM_CH | Latched open load per channel |
| rd_done | input | 1 | One-cycle strobe: status byte has been shifted out |
| status_byte | output | ADDR_W+6 | Status byte (combinational view of current state) |
| fault_n | output | 1 | Active-low combined fault indication |

## Verification
The bench sweeps every combination of the twelve load fault inputs. It tracks its own poll pointer across combinations, so each combination starts from an arbitrary pointer. A design that scans from the wrong end would report a lower channel first. One that fails to wrap would stall on the highest channel, and one that advances by one instead of skipping to the next faulted channel would report a clean channel. The bench also checks the system flags around the moment of the read strobe. A design that clears a flag while its condition is still live loses a standing fault. One that clears on the falling edge of the condition loses the record before the host sees it. The bench checks that the summary line agrees with the byte in every combination.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Bit positions inside the status byte, counted from bit 0
  localparam int BIT_STG  = 0;
  localparam int BIT_STB  = 1;
  localparam int BIT_OL   = 2;
  localparam int BIT_TW   = 3;
  localparam int BIT_CP   = 4;
  localparam int BIT_ZERO = 5;
  localparam int BIT_ADDR = 6;

  // System flag indices
  localparam int SYS_CP  = 0;
  localparam int SYS_TW  = 1;
  localparam int NUM_SYS = 2;

  typedef struct packed {
    logic ol;
    logic stb;
    logic stg;
  } load_flags_t;
endpackage

// File: rtl/fs_sticky.sv
module fs_sticky #(
  parameter int NUM_FLAGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] live,
  input  logic                 rd_done,
  output logic [NUM_FLAGS-1:0] visible
);
  logic [NUM_FLAGS-1:0] held_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        held_q[g] <= 1'b0;
      else if (live[g])
        held_q[g] <= 1'b1;
      else if (rd_done)
        held_q[g] <= 1'b0;
    end
    assign visible[g] = live[g] | held_q[g];
  end
endmodule

// File: rtl/fs_picker.sv
module fs_picker #(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] fault_mask,
  input  logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] sel_idx,
  output logic              sel_valid
);
  // Lowest set bit at or above start, else lowest set bit overall
  function automatic logic [ADDR_W:0] pick(input logic [NUM_CH-1:0] m,
                                           input logic [ADDR_W-1:0] s);
    logic              hit_hi;
    logic              hit_any;
    logic [ADDR_W-1:0] idx_hi;
    logic [ADDR_W-1:0] idx_lo;
    hit_hi  = 1'b0;
    hit_any = 1'b0;
    idx_hi  = '0;
    idx_lo  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit_any = 1'b1;
        idx_lo  = i[ADDR_W-1:0];
        if (i[ADDR_W-1:0] >= s) begin
          hit_hi = 1'b1;
          idx_hi = i[ADDR_W-1:0];
        end
      end
    end
    return {hit_any, hit_hi ? idx_hi : idx_lo};
  endfunction

  logic [ADDR_W:0] res;
  assign res       = pick(fault_mask, start);
  assign sel_valid = res[ADDR_W];
  assign sel_idx   = res[ADDR_W-1:0];
endmodule

// File: rtl/fs_poll.sv
module fs_poll #(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic              sel_valid,
  input  logic [ADDR_W-1:0] sel_idx,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_CH - 1);

  function automatic logic [ADDR_W-1:0] succ(input logic [ADDR_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (rd_done && sel_valid)
      ptr <= succ(sel_idx);
  end
endmodule

// File: rtl/fault_status_reporter.sv
module fault_status_reporter
  import fs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int STAT_W = ADDR_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_uv_live,
  input  logic              therm_live,
  input  logic [NUM_CH-1:0] ch_stg,
  input  logic [NUM_CH-1:0] ch_stb,
  input  logic [NUM_CH-1:0] ch_ol,
  input  logic              rd_done,
  output logic [STAT_W-1:0] status_byte,
  output logic              fault_n
);
  // Named internal events, also used by the checker
  logic [NUM_CH-1:0]  ch_faulted;
  logic [NUM_SYS-1:0] sys_live;
  logic [NUM_SYS-1:0] sys_vis;
  logic [ADDR_W-1:0]  poll_ptr;
  logic [ADDR_W-1:0]  sel_idx;
  logic               sel_valid;
  load_flags_t        sel_flags;

  assign ch_faulted       = ch_stg | ch_stb | ch_ol;
  assign sys_live[SYS_CP] = cp_uv_live;
  assign sys_live[SYS_TW] = therm_live;

  fs_sticky #(.NUM_FLAGS(NUM_SYS)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .live    (sys_live),
    .rd_done (rd_done),
    .visible (sys_vis)
  );

  fs_picker #(.NUM_CH(NUM_CH)) u_picker (
    .fault_mask (ch_faulted),
    .start      (poll_ptr),
    .sel_idx    (sel_idx),
    .sel_valid  (sel_valid)
  );

  fs_poll #(.NUM_CH(NUM_CH)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_done   (rd_done),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .ptr       (poll_ptr)
  );

  always_comb begin
    sel_flags = '0;
    if (sel_valid) begin
      sel_flags.stg = ch_stg[sel_idx];
      sel_flags.stb = ch_stb[sel_idx];
      sel_flags.ol  = ch_ol[sel_idx];
    end
  end

  always_comb begin
    status_byte                        = '0;
    status_byte[BIT_STG]               = sel_flags.stg;
    status_byte[BIT_STB]               = sel_flags.stb;
    status_byte[BIT_OL]                = sel_flags.ol;
    status_byte[BIT_TW]                = sys_vis[SYS_TW];
    status_byte[BIT_CP]                = sys_vis[SYS_CP];
    status_byte[BIT_ZERO]              = 1'b0;
    status_byte[STAT_W-1:BIT_ADDR]     = sel_valid ? sel_idx : '0;
  end

  assign fault_n = ~((|ch_faulted) | (|sys_vis));
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int STAT_W = ADDR_W + 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cp_uv_live,
  input logic              therm_live,
  input logic              rd_done,
  input logic [NUM_CH-1:0] ch_faulted,
  input logic              sel_valid,
  input logic [STAT_W-1:0] status_byte,
  input logic              fault_n
);
  a_r2_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[5] == 1'b0);

  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_uv_live && status_byte[4] && !rd_done) |=> status_byte[4]);

  a_r8_live_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_uv_live && rd_done) |=> status_byte[4]);

  a_r8_tw_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_live && rd_done) |=> status_byte[3]);

  a_r9_summary_line: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n == !(|status_byte[4:0]));

  a_r4_addr_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ch_faulted) |-> (status_byte[STAT_W-1:6] == '0 && sel_valid == 1'b0));

  a_r10_no_read_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> ($stable(ch_faulted) -> $stable(status_byte[STAT_W-1:6])));
endmodule

bind fault_status_reporter fs_checker #(.NUM_CH(NUM_CH)) u_fs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cp_uv_live  (cp_uv_live),
  .therm_live  (therm_live),
  .rd_done     (rd_done),
  .ch_faulted  (ch_faulted),
  .sel_valid   (sel_valid),
  .status_byte (status_byte),
  .fault_n     (fault_n)
);

// File: tb/fault_status_reporter_bench.sv
module fault_status_reporter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cp_uv_live = 1'b0;
  logic       therm_live = 1'b0;
  logic [3:0] ch_stg = '0;
  logic [3:0] ch_stb = '0;
  logic [3:0] ch_ol = '0;
  logic       rd_done = 1'b0;
  logic [7:0] status_byte;
  logic       fault_n;

  int errors = 0;
  int checks = 0;
  int m_ptr  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fault_status_reporter u_fault_status_reporter (
    .clk (clk), .rst_n (rst_n), .cp_uv_live (cp_uv_live), .therm_live (therm_live),
    .ch_stg (ch_stg), .ch_stb (ch_stb), .ch_ol (ch_ol), .rd_done (rd_done),
    .status_byte (status_byte), .fault_n (fault_n)
  );

  // Channel the byte should name: scan upward from the pointer, modulo 4
  function automatic int exp_chan(input logic [3:0] m, input int p);
    for (int k = 0; k < 4; k++)
      if (m[(p + k) % 4]) return (p + k) % 4;
    return -1;
  endfunction

  function automatic logic [7:0] exp_byte(input int c, input logic cp, input logic tw);
    logic [7:0] b;
    b = {3'b000, cp, tw, 3'b000};
    if (c >= 0) begin
      b[7:6] = 2'(c);
      b[2] = ch_ol[c];
      b[1] = ch_stb[c];
      b[0] = ch_stg[c];
    end
    return b;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: status_byte=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: fault_n=%b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_read();
    @(negedge clk) rd_done = 1'b1;
    @(negedge clk) rd_done = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk8("R1 reset byte", status_byte, 8'h00);
    chk1("R1 reset fault_n", fault_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk) #1;
    chk8("R2 idle byte", status_byte, 8'h00);

    // R4 example: STB on channel 3
    @(negedge clk) ch_stb = 4'b0100;
    #1 chk8("R4 stb ch3", status_byte, 8'b10000010);
    chk1("R9 load fault", fault_n, 1'b0);
    ch_stb = '0;

    // R5 example: OL ch2 and STG ch4
    @(negedge clk) ch_ol = 4'b0010; ch_stg = 4'b1000;
    #1 chk8("R5 first", status_byte, 8'b01000100);
    pulse_read();
    chk8("R5 second", status_byte, 8'b11000001);
    pulse_read();
    chk8("R5 wrap", status_byte, 8'b01000100);
    pulse_read();
    m_ptr = 0;
    ch_ol = '0; ch_stg = '0;
    #1 chk8("R2 cleared", status_byte, 8'h00);

    // R3 / R7 / R8: system flags
    @(negedge clk) cp_uv_live = 1'b1; therm_live = 1'b1;
    #1 chk8("R3 both live", status_byte, 8'b00011000);
    @(negedge clk) cp_uv_live = 1'b0;
    #1 chk8("R7 cp held", status_byte, 8'b00011000);
    repeat (3) @(negedge clk);
    #1 chk8("R7 cp still held", status_byte, 8'b00011000);
    pulse_read();
    chk8("R8 tw live survives, cp cleared", status_byte, 8'b00001000);
    @(negedge clk) therm_live = 1'b0;
    #1 chk8("R7 tw held", status_byte, 8'b00001000);
    chk1("R9 sys flag", fault_n, 1'b0);
    pulse_read();
    chk8("R8 tw cleared", status_byte, 8'h00);
    chk1("R9 idle", fault_n, 1'b1);

    // Exhaustive sweep of load fault inputs; pointer carried by the bench model
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 4096; v++) begin
        if (pass == 1 && (v % 16) != 5) continue;
        @(negedge clk);
        ch_stg = v[3:0]; ch_stb = v[7:4]; ch_ol = v[11:8];
        cp_uv_live = (pass == 1); therm_live = (pass == 1);
        #1;
        begin
          logic [3:0] m;
          int c;
          m = ch_stg | ch_stb | ch_ol;
          c = exp_chan(m, m_ptr);
          chk8("R4 R6 sweep", status_byte, exp_byte(c, pass == 1, pass == 1));
          chk1("R9 sweep", fault_n, !((m != 0) || pass == 1));
          @(negedge clk) #1;
          chk8("R10 no read stable", status_byte, exp_byte(c, pass == 1, pass == 1));
          for (int r = 0; r < 2; r++) begin
            pulse_read();
            if (c >= 0) m_ptr = (c + 1) % 4;
            c = exp_chan(m, m_ptr);
            chk8("R5 R6 rotation", status_byte, exp_byte(c, pass == 1, pass == 1));
          end
        end
      end
    end
    @(negedge clk) cp_uv_live = 1'b0; therm_live = 1'b0; ch_stg = '0; ch_stb = '0; ch_ol = '0;
    pulse_read();
    chk8("R2 final idle", status_byte, 8'h00);
    done = 1'b1;
    summary();
  end
endmodule